// File: doc/BRIEF.md
# Compressed-Instruction Enable and Return-Target Control

This block is a small machine-mode control-register slice for a RISC-V style core. It keeps two pieces of state. The first is the enable bit for 16-bit (compressed) instructions, which sits inside the ISA description register. The second is the saved exception-return address. The pipeline issues read, write, set and clear operations to either register. It also supplies the address of the instruction that will be fetched next.

From that state the block produces two outputs. One is the target that an mret jumps to. The other is a flag that tells the fetch unit whether halfword-aligned fetch is legal.

Two rules set it apart from a plain register file:
- An operation that would turn compressed instructions off is dropped without any exception when the next fetch address is only halfword aligned. This keeps the core from stranding itself on a misaligned PC.
- While compressed instructions are off, the saved return address is read and used with bit 1 forced low. An mret to a halfword-aligned saved address therefore lands on the enclosing word and never faults.

Top module: `cext_csr_slice`

## Requirements
- R1: After reset the compressed enable is 1, the stored return address is 0, and `half_align_ok` is 1.
- R2: A read of the ISA register (address 0x301) returns the enable in bit 2 and zero in every other bit, in the same cycle as the request.
- R3: Write (op 1), set (op 2) and clear (op 3) to the ISA register change the enable from bit 2 of the data, using read-modify-write rules. The change is visible from the cycle after the request. Data bits other than bit 2 have no effect, and read (op 0) changes nothing.
- R4: When bit 1 of `next_fetch_pc` is 1, any ISA operation that would drop the enable to 0 is ignored and the enable stays 1.
- R5: A set of bit 2 on the ISA register always turns the enable on, whatever the value of `next_fetch_pc`.
- R6: Write, set and clear to the return-address register (address 0x341) update it from the next cycle, with bit 0 always stored as 0.
- R7: While the enable is 1, `ret_target` and a read of the return-address register give the stored value unchanged, including bit 1.
- R8: While the enable is 0, `ret_target` and a read of the return-address register give the stored value with bit 1 cleared. The stored value itself is kept.
- R9: `half_align_ok` equals the compressed enable in every cycle.
- R10: An operation at any other address reads as zero and changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_valid | input | 1 | CSR operation request this cycle |
| csr_op | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | Operand for write, or mask for set and clear |
| next_fetch_pc | input | XLEN | Address of the next instruction fetch |
| csr_rdata | output | XLEN | Read data, combinational |
| ret_target | output | XLEN | Effective mret destination |
| half_align_ok | output | 1 | Halfword-aligned fetch is currently legal |

## Verification
The hardest situation to reach is a disable request that arrives while the next fetch address is halfword aligned. It matters most when the request is not an obvious clear, for example a full write whose other bits are all ones. The stimulus table drives `next_fetch_pc` bit 1 high alongside both a clear and a bit-2-low write, and checks that the enable survives. A disable then follows with bit 1 low.

While the enable is off, a return address with bit 1 set is loaded. The bench then checks that `ret_target` masks the bit, and that the stored bit returns once a set re-enables compressed instructions.

// File: rtl/cext_csr_slice.sv
module cext_csr_slice #(
  parameter int          XLEN     = 32,
  parameter logic [11:0] ISA_ADDR = 12'h301,
  parameter logic [11:0] EPC_ADDR = 12'h341,
  parameter int          CBIT     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_valid,
  input  logic [1:0]      csr_op,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic [XLEN-1:0] next_fetch_pc,
  output logic [XLEN-1:0] csr_rdata,
  output logic [XLEN-1:0] ret_target,
  output logic            half_align_ok
);
  localparam logic [1:0] OP_WR = 2'd1, OP_SET = 2'd2, OP_CLR = 2'd3;
  localparam logic [XLEN-1:0] HALF_MASK = XLEN'(2);

  logic            c_en;
  logic [XLEN-1:0] epc;
  logic            c_next, c_req;
  logic [XLEN-1:0] epc_next, epc_eff;
  logic            hit_isa, hit_epc;

  wire unused_pc = ^{next_fetch_pc[XLEN-1:2], next_fetch_pc[0]};

  assign hit_isa = csr_valid && (csr_addr == ISA_ADDR);
  assign hit_epc = csr_valid && (csr_addr == EPC_ADDR);

  always_comb begin
    case (csr_op)
      OP_WR:   c_req = csr_wdata[CBIT];
      OP_SET:  c_req = c_en | csr_wdata[CBIT];
      OP_CLR:  c_req = c_en & ~csr_wdata[CBIT];
      default: c_req = c_en;
    endcase
    c_next = (!c_req && next_fetch_pc[1]) ? c_en : c_req;
  end

  always_comb begin
    case (csr_op)
      OP_WR:   epc_next = csr_wdata;
      OP_SET:  epc_next = epc | csr_wdata;
      OP_CLR:  epc_next = epc & ~csr_wdata;
      default: epc_next = epc;
    endcase
    epc_next[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_en <= 1'b1;
      epc  <= '0;
    end else begin
      if (hit_isa) c_en <= c_next;
      if (hit_epc) epc  <= epc_next;
    end
  end

  assign epc_eff       = c_en ? epc : (epc & ~HALF_MASK);
  assign ret_target    = epc_eff;
  assign half_align_ok = c_en;

  always_comb begin
    csr_rdata = '0;
    if (hit_isa)      csr_rdata[CBIT] = c_en;
    else if (hit_epc) csr_rdata = epc_eff;
  end
endmodule

module cext_csr_slice_chk #(
  parameter int          XLEN     = 32,
  parameter logic [11:0] ISA_ADDR = 12'h301,
  parameter logic [11:0] EPC_ADDR = 12'h341
) (
  input logic            clk,
  input logic            rst_n,
  input logic            csr_valid,
  input logic [1:0]      csr_op,
  input logic [11:0]     csr_addr,
  input logic            wbit,
  input logic            npc_half,
  input logic [XLEN-1:0] csr_rdata,
  input logic [XLEN-1:0] ret_target,
  input logic            half_align_ok
);
  logic isa_hit, other_hit;
  assign isa_hit   = csr_valid && csr_addr == ISA_ADDR;
  assign other_hit = csr_valid && csr_addr != ISA_ADDR && csr_addr != EPC_ADDR;

  p_isa_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    isa_hit |-> (csr_rdata[2] == half_align_ok) && ($countones(csr_rdata) <= 1));

  p_keep_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (isa_hit && npc_half && half_align_ok) |=> half_align_ok);

  p_set_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (isa_hit && csr_op == 2'd2 && wbit) |=> half_align_ok);

  p_bit0_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ret_target[0] == 1'b0);

  p_mask_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !half_align_ok |-> ret_target[1] == 1'b0);

  p_other_r10: assert property (@(posedge clk) disable iff (!rst_n)
    other_hit |-> csr_rdata == '0 ##1 1'b1);

  p_other_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    other_hit |=> $stable(half_align_ok) && $stable(ret_target));

  p_read_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_valid && csr_op == 2'd0) |=> $stable(half_align_ok) && $stable(ret_target));
endmodule

bind cext_csr_slice cext_csr_slice_chk #(.XLEN(XLEN), .ISA_ADDR(ISA_ADDR), .EPC_ADDR(EPC_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_op(csr_op), .csr_addr(csr_addr),
  .wbit(csr_wdata[2]), .npc_half(next_fetch_pc[1]), .csr_rdata(csr_rdata),
  .ret_target(ret_target), .half_align_ok(half_align_ok)
);

// File: tb/sim_cext_csr_slice.sv
module sim_cext_csr_slice;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_valid = 1'b0;
  logic [1:0]  csr_op = '0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] next_fetch_pc = '0;
  logic [31:0] csr_rdata, ret_target;
  logic        half_align_ok;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cext_csr_slice u0 (.*);

  // {op, sel(0 isa,1 epc,2 other), wdata, npc bit1, expected enable, expected ret_target}
  localparam int NV = 13;
  localparam logic [69:0] VEC [NV] = '{
    {2'd1, 2'd1, 32'h1002_0006, 1'b0, 1'b1, 32'h1002_0006},  // R6 R7
    {2'd1, 2'd1, 32'h0000_1237, 1'b0, 1'b1, 32'h0000_1236},  // R6
    {2'd3, 2'd0, 32'h0000_0004, 1'b1, 1'b1, 32'h0000_1236},  // R4
    {2'd1, 2'd0, 32'hFFFF_FFF0, 1'b1, 1'b1, 32'h0000_1236},  // R4
    {2'd3, 2'd0, 32'h0000_0004, 1'b0, 1'b0, 32'h0000_1234},  // R3 R8
    {2'd1, 2'd1, 32'h8000_000E, 1'b1, 1'b0, 32'h8000_000C},  // R8
    {2'd2, 2'd0, 32'h0000_0004, 1'b1, 1'b1, 32'h8000_000E},  // R5 R7
    {2'd1, 2'd0, 32'hFFFF_FFFB, 1'b0, 1'b0, 32'h8000_000C},  // R3
    {2'd1, 2'd2, 32'h0000_0004, 1'b0, 1'b0, 32'h8000_000C},  // R10
    {2'd1, 2'd0, 32'h0000_0004, 1'b0, 1'b1, 32'h8000_000E},  // R3
    {2'd2, 2'd1, 32'h0000_0001, 1'b0, 1'b1, 32'h8000_000E},  // R6
    {2'd3, 2'd1, 32'h8000_0000, 1'b0, 1'b1, 32'h0000_000E},  // R6
    {2'd2, 2'd0, 32'h0000_0003, 1'b0, 1'b1, 32'h0000_000E}   // R3
  };

  function automatic logic [11:0] sel_addr(input logic [1:0] s);
    return (s == 2'd0) ? 12'h301 : (s == 2'd1) ? 12'h341 : 12'h7C0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] o, input logic [11:0] a, input logic [31:0] d, input logic npc1);
    @(negedge clk);
    csr_valid = 1'b1; csr_op = o; csr_addr = a; csr_wdata = d;
    next_fetch_pc = 32'h0000_4000 | {30'd0, npc1, 1'b0};
    #1;
  endtask

  task automatic finish_op;
    @(posedge clk); #5;
    csr_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    check("R1 enable", {31'd0, half_align_ok}, 32'd1);
    check("R1 ret", ret_target, 32'd0);
    op(2'd0, 12'h301, 32'd0, 1'b0);
    check("R2 read on", csr_rdata, 32'h4);
    finish_op();

    for (int i = 0; i < NV; i++) begin
      op(VEC[i][69:68], sel_addr(VEC[i][67:66]), VEC[i][65:34], VEC[i][33]);
      finish_op();
      check($sformatf("vec%0d enable R3/R4/R5/R9", i), {31'd0, half_align_ok}, {31'd0, VEC[i][32]});
      check($sformatf("vec%0d ret R6/R7/R8", i), ret_target, VEC[i][31:0]);
    end

    op(2'd3, 12'h301, 32'h4, 1'b0);
    finish_op();
    check("R9 off", {31'd0, half_align_ok}, 32'd0);
    op(2'd0, 12'h341, 32'd0, 1'b0);
    check("R8 read masked", csr_rdata, 32'h0000_000C);
    finish_op();
    op(2'd0, 12'h301, 32'd0, 1'b1);
    check("R2 read off", csr_rdata, 32'h0);
    finish_op();
    check("R3 read no change", {31'd0, half_align_ok}, 32'd0);
    op(2'd0, 12'h7C0, 32'hFFFF_FFFF, 1'b0);
    check("R10 read zero", csr_rdata, 32'h0);
    finish_op();
    op(2'd2, 12'h301, 32'h4, 1'b1);
    finish_op();
    check("R5 set on", {31'd0, half_align_ok}, 32'd1);
    op(2'd0, 12'h341, 32'd0, 1'b0);
    check("R7 read full", csr_rdata, 32'h0000_000E);
    finish_op();

    @(negedge clk) rst_n = 1'b0;
    op(2'd1, 12'h341, 32'h55, 1'b0);
    finish_op();
    rst_n = 1'b1;
    check("R1 reset ret", ret_target, 32'd0);
    check("R1 reset enable", {31'd0, half_align_ok}, 32'd1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule